// File: doc/BRIEF.md
# Byte-Wide SPI Master Shift Engine

This block runs one 8-bit SPI master transfer at a time. It is driven by a small register bus with two addresses. The data address serves both directions. A host write there, when no transfer is running, loads the byte and starts a transfer. A host read there returns the receive buffer. The status address reports a transfer-done flag, a write-collision flag and the busy state.

The transfer sequencer is a four-state machine:
- `ST_IDLE` waits for an accepted data write (transition *start*) and then moves to `ST_LEAD`.
- `ST_LEAD` pulls the select low and presents the MSB for half a serial-clock period (transition *lead_end*), then moves to `ST_HIGH`.
- `ST_HIGH` drives SCK high and samples MISO on entry. When its half period ends, it moves to `ST_LOW` (transition *bit_next*) or, after the eighth bit, back to `ST_IDLE` (transition *finish*).
- `ST_LOW` drives SCK low and presents the next bit. It returns to `ST_HIGH` at the end of its half period (transition *low_end*).

SCK runs at one quarter of the system clock. Bits leave MSB first and change on SCK falling edges. MISO is captured on rising edges.

A data write made while a transfer runs is dropped and raises the collision flag. The flags clear by a two-step sequence: a status read that sees the flag set, followed by any access to the data address. A transfer that completes while the done flag is still set loses its received byte. The buffer keeps the first unread byte.

Top module: `spi_byte_engine`

## Requirements
- R1: After reset, the receive buffer reads 0x00 and the status reads 0x00. `busy` is low, `ss_n` is high and `sck` is low.
- R2: A write to the data address (`bus_addr`=1) while idle starts a transfer. `busy` is high from the accepting clock edge for exactly 32 system clocks.
- R3: The written byte appears on `mosi` MSB first. Each bit is stable at every SCK rising edge, and the bits change only after falling edges.
- R4: MISO is sampled at each SCK rising edge. The first sampled bit becomes bit 7 of the received byte.
- R5: Each transfer gives exactly 8 SCK high pulses, each 2 clocks long, with SCK low when idle. `ss_n` is low for the whole time `busy` is high and high otherwise.
- R6: The done flag sets on the same clock edge at which `busy` falls.
- R7: A data write while `busy` is high has no effect on the byte being shifted out, and it sets the collision flag.
- R8: The receive buffer takes the new byte at completion only if the done flag was clear. Otherwise the new byte is discarded and the old value stays readable.
- R9: A flag clears only when a status read that saw it set is followed by a read or write at the data address. A data access with no such prior status read leaves the flag set.
- R10: The status address (`bus_addr`=0) reads bit 7 = done, bit 6 = collision, bit 0 = busy, with the other bits zero. Writes to the status address are ignored.
- R11: The receive buffer can be read at any time, including during a following transfer, and shows the last latched byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_en | input | 1 | Register access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 1 | 0 = status, 1 = data |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register (combinational) |
| sck | output | 1 | Serial clock, idles low |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| ss_n | output | 1 | Active-low select, low during a transfer |
| busy | output | 1 | Transfer in progress |
| done_flag | output | 1 | Transfer-done flag |
| wcol_flag | output | 1 | Write-collision flag |

## Verification
`busy` rises at the clock edge that accepts the write and falls 32 edges later, at the same edge where the done flag and the receive buffer update. The bench therefore counts negative clock edges while `busy` is high and expects exactly 32, then reads the flags and the buffer only after `busy` has dropped. Bus reads are sampled one time unit after the access is driven, before the next rising edge, because read data is combinational. Flag clearing takes effect at that rising edge, so it is observed on the next status read. MOSI and SCK pulses are captured on SCK rising edges by a slave model that moves MISO on falling edges. Expected bytes come from the sweep index.

// File: rtl/spi_eng_pkg.sv
package spi_eng_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LEAD = 2'd1,
        ST_HIGH = 2'd2,
        ST_LOW  = 2'd3
    } seq_state_t;

    localparam logic ADDR_STATUS = 1'b0;
    localparam logic ADDR_DATA   = 1'b1;

endpackage

// File: rtl/spi_seq_fsm.sv
module spi_seq_fsm
    import spi_eng_pkg::*;
#(
    parameter int HALF_CLKS = 2,
    parameter int NBITS     = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic sck,
    output logic ss_n,
    output logic busy,
    output logic sample_en,
    output logic shift_en,
    output logic finish
);

    localparam int HCW = (HALF_CLKS > 1) ? $clog2(HALF_CLKS) : 1;
    localparam int BCW = (NBITS > 1) ? $clog2(NBITS) : 1;
    localparam logic [HCW-1:0] HALF_LAST = HCW'(HALF_CLKS - 1);
    localparam logic [BCW-1:0] BIT_LAST  = BCW'(NBITS - 1);

    seq_state_t state, state_n;
    logic [HCW-1:0] hcnt;
    logic [BCW-1:0] bcnt;
    logic half_end;
    logic last_bit;

    assign half_end = (hcnt == HALF_LAST);
    assign last_bit = (bcnt == BIT_LAST);

    // next-state logic
    always_comb begin
        state_n = state;
        unique case (state)
            ST_IDLE: if (start)    state_n = ST_LEAD;
            ST_LEAD: if (half_end) state_n = ST_HIGH;
            ST_HIGH: if (half_end) state_n = last_bit ? ST_IDLE : ST_LOW;
            ST_LOW:  if (half_end) state_n = ST_HIGH;
            default: state_n = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_n;
    end

    // half-period and bit counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hcnt <= '0;
            bcnt <= '0;
        end else begin
            if (state == ST_IDLE || state_n != state) hcnt <= '0;
            else                                      hcnt <= hcnt + 1'b1;
            if (state == ST_IDLE)                          bcnt <= '0;
            else if (state == ST_HIGH && state_n == ST_LOW) bcnt <= bcnt + 1'b1;
        end
    end

    // registered pin outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck  <= 1'b0;
            ss_n <= 1'b1;
        end else begin
            sck  <= (state_n == ST_HIGH);
            ss_n <= (state_n == ST_IDLE);
        end
    end

    // strobes to the datapath
    always_comb begin
        busy      = (state != ST_IDLE);
        sample_en = (state == ST_LEAD || state == ST_LOW) && half_end;
        shift_en  = (state == ST_HIGH) && half_end;
        finish    = (state == ST_HIGH) && half_end && last_bit;
    end

    p_ss_tracks_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ss_n == !busy);
    p_sck_idle_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !sck);
    p_sck_pulse_width_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sck) |=> sck);
    p_start_idle_only_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

endmodule

// File: rtl/spi_shift_reg.sv
module spi_shift_reg #(
    parameter int NBITS = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [NBITS-1:0] load_data,
    input  logic             sample_en,
    input  logic             shift_en,
    input  logic             miso,
    output logic             mosi,
    output logic [NBITS-1:0] rx_word
);

    logic [NBITS-1:0] shreg;
    logic             samp;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg <= '0;
            samp  <= 1'b0;
        end else begin
            if (sample_en) samp <= miso;
            if (load)          shreg <= load_data;
            else if (shift_en) shreg <= {shreg[NBITS-2:0], samp};
        end
    end

    assign mosi    = shreg[NBITS-1];
    assign rx_word = {shreg[NBITS-2:0], samp};

    p_mosi_steady_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !shift_en) |=> $stable(mosi));

endmodule

// File: rtl/spi_flag_unit.sv
module spi_flag_unit #(
    parameter int NBITS = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             finish,
    input  logic [NBITS-1:0] rx_word,
    input  logic             stat_rd,
    input  logic             data_acc,
    input  logic             data_wr_busy,
    output logic             done,
    output logic             wcol,
    output logic [NBITS-1:0] rx_buf
);

    logic arm_done;
    logic arm_wcol;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done     <= 1'b0;
            wcol     <= 1'b0;
            arm_done <= 1'b0;
            arm_wcol <= 1'b0;
            rx_buf   <= '0;
        end else begin
            if (finish)                    done <= 1'b1;
            else if (data_acc && arm_done) done <= 1'b0;

            if (data_wr_busy)              wcol <= 1'b1;
            else if (data_acc && arm_wcol) wcol <= 1'b0;

            if (data_acc) begin
                arm_done <= 1'b0;
                arm_wcol <= 1'b0;
            end else if (stat_rd) begin
                arm_done <= done;
                arm_wcol <= wcol;
            end

            if (finish && !done) rx_buf <= rx_word;
        end
    end

    p_rx_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> $stable(rx_buf));
    p_wcol_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
        data_wr_busy |=> wcol);
    p_clear_needs_arm_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !arm_done) |=> done);

endmodule

// File: rtl/spi_byte_engine.sv
module spi_byte_engine
    import spi_eng_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int HALF_CLKS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_en,
    input  logic              bus_we,
    input  logic              bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              sck,
    output logic              mosi,
    input  logic              miso,
    output logic              ss_n,
    output logic              busy,
    output logic              done_flag,
    output logic              wcol_flag
);

    localparam int STAT_DONE = DATA_W - 1;
    localparam int STAT_WCOL = DATA_W - 2;
    localparam int STAT_BUSY = 0;

    logic data_sel, start, data_wr_busy, stat_rd, data_acc;
    logic sample_en, shift_en, finish;
    logic [DATA_W-1:0] rx_word, rx_buf, status;

    assign data_sel     = bus_en && (bus_addr == ADDR_DATA);
    assign start        = data_sel && bus_we && !busy;
    assign data_wr_busy = data_sel && bus_we && busy;
    assign data_acc     = data_sel;
    assign stat_rd      = bus_en && !bus_we && (bus_addr == ADDR_STATUS);

    spi_seq_fsm #(.HALF_CLKS(HALF_CLKS), .NBITS(DATA_W)) seq_i (
        .clk(clk), .rst_n(rst_n), .start(start),
        .sck(sck), .ss_n(ss_n), .busy(busy),
        .sample_en(sample_en), .shift_en(shift_en), .finish(finish)
    );

    spi_shift_reg #(.NBITS(DATA_W)) shf_i (
        .clk(clk), .rst_n(rst_n), .load(start), .load_data(bus_wdata),
        .sample_en(sample_en), .shift_en(shift_en), .miso(miso),
        .mosi(mosi), .rx_word(rx_word)
    );

    spi_flag_unit #(.NBITS(DATA_W)) flg_i (
        .clk(clk), .rst_n(rst_n), .finish(finish), .rx_word(rx_word),
        .stat_rd(stat_rd), .data_acc(data_acc), .data_wr_busy(data_wr_busy),
        .done(done_flag), .wcol(wcol_flag), .rx_buf(rx_buf)
    );

    always_comb begin
        status            = '0;
        status[STAT_DONE] = done_flag;
        status[STAT_WCOL] = wcol_flag;
        status[STAT_BUSY] = busy;
        bus_rdata = (bus_addr == ADDR_DATA) ? rx_buf : status;
    end

    p_done_ends_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_flag) |-> $fell(busy));

endmodule

// File: tb/spi_byte_engine_tb_top.sv
module spi_byte_engine_tb_top;

    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_en = 1'b0, bus_we = 1'b0, bus_addr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic sck, mosi, ss_n, busy, done_flag, wcol_flag;
    logic miso;

    int nchk = 0;
    int nerr = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_byte_engine dut_i (
        .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .sck(sck), .mosi(mosi), .miso(miso), .ss_n(ss_n), .busy(busy),
        .done_flag(done_flag), .wcol_flag(wcol_flag)
    );

    // slave model: MISO moves after each SCK fall, MOSI captured on SCK rise
    logic [7:0] slave_byte = '0;
    int         sidx = 0;
    logic [7:0] mosi_cap = '0;
    int         sck_rises = 0;

    always @(negedge sck or posedge ss_n) begin
        if (ss_n) sidx <= 0;
        else      sidx <= sidx + 1;
    end
    assign miso = (sidx < 8) ? slave_byte[7 - sidx] : 1'b0;

    always @(posedge sck) mosi_cap <= {mosi_cap[6:0], mosi};
    always @(posedge sck or negedge ss_n) begin
        if (sck) sck_rises <= sck_rises + 1;
        else     sck_rises <= 0;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic a, input logic [7:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0;
    endtask

    task automatic bus_read(input logic a, output logic [7:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_en = 1'b0;
    endtask

    task automatic wait_idle(output int cnt, output bit ss_ok);
        cnt = 0; ss_ok = 1'b1;
        while (busy && cnt < 200) begin
            if (ss_n) ss_ok = 1'b0;
            cnt++;
            @(negedge clk);
        end
    endtask

    task automatic run_xfer(input logic [7:0] tx, input logic [7:0] sb,
                            input bit do_clear, input logic [7:0] exp_rx);
        int cnt; bit ss_ok; logic [7:0] d;
        slave_byte = sb;
        bus_write(1'b1, tx);
        wait_idle(cnt, ss_ok);
        chk(cnt == 32, "R2", cnt, 32);
        chk(ss_ok && ss_n, "R5", ss_ok, 1);
        chk(sck_rises == 8, "R5", sck_rises, 8);
        chk(mosi_cap == tx, "R3", mosi_cap, tx);
        chk(done_flag == 1'b1, "R6", done_flag, 1);
        if (do_clear) begin
            bus_read(1'b0, d); chk(d == 8'h80, "R10", d, 8'h80);
            bus_read(1'b1, d); chk(d == exp_rx, "R4", d, exp_rx);
            bus_read(1'b0, d); chk(d == 8'h00, "R9", d, 8'h00);
        end
    endtask

    task automatic finish_run;
        $display("  Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nchk++; nerr++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [7:0] d;
        int cnt; bit ss_ok;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(busy == 1'b0 && ss_n == 1'b1 && sck == 1'b0, "R1", {busy, ss_n, sck}, 3'b010);
        bus_read(1'b0, d); chk(d == 8'h00, "R1", d, 0);
        bus_read(1'b1, d); chk(d == 8'h00, "R1", d, 0);

        // sweep of transmit and receive patterns (R2 R3 R4 R5 R6 R9 R10)
        for (int i = 0; i < 256; i++) begin
            logic [7:0] sb;
            sb = 8'((i * 37 + 11) & 255);
            run_xfer(8'(i), sb, 1'b1, sb);
        end

        // R10: status write ignored, nothing starts
        bus_write(1'b0, 8'hFF);
        repeat (3) @(negedge clk);
        chk(busy == 1'b0, "R10", busy, 0);
        bus_read(1'b0, d); chk(d == 8'h00, "R10", d, 0);

        // R7: collision during a transfer
        slave_byte = 8'h96;
        bus_write(1'b1, 8'hA3);
        repeat (5) @(negedge clk);
        bus_write(1'b1, 8'h5C);
        bus_read(1'b0, d); chk(d == 8'h41, "R7", d, 8'h41);
        wait_idle(cnt, ss_ok);
        chk(mosi_cap == 8'hA3, "R7", mosi_cap, 8'hA3);
        bus_read(1'b0, d); chk(d == 8'hC0, "R7", d, 8'hC0);
        bus_read(1'b1, d); chk(d == 8'h96, "R4", d, 8'h96);
        bus_read(1'b0, d); chk(d == 8'h00, "R9", d, 0);

        // R11: buffer readable during the next transfer
        slave_byte = 8'h0F;
        bus_write(1'b1, 8'h11);
        repeat (4) @(negedge clk);
        bus_read(1'b1, d); chk(d == 8'h96, "R11", d, 8'h96);
        wait_idle(cnt, ss_ok);
        // R9: data read without a prior status read leaves done set
        bus_read(1'b1, d); chk(d == 8'h0F, "R11", d, 8'h0F);
        bus_read(1'b0, d); chk(d == 8'h80, "R9", d, 8'h80);
        bus_read(1'b1, d);
        bus_read(1'b0, d); chk(d == 8'h00, "R9", d, 0);

        // R9: status read while done is clear does not arm
        slave_byte = 8'h77;
        bus_write(1'b1, 8'h22);
        bus_read(1'b0, d); chk(d == 8'h01, "R10", d, 8'h01);
        wait_idle(cnt, ss_ok);
        bus_read(1'b1, d); chk(d == 8'h77, "R4", d, 8'h77);
        chk(done_flag == 1'b1, "R9", done_flag, 1);
        bus_read(1'b0, d);
        bus_read(1'b1, d);
        bus_read(1'b0, d); chk(d == 8'h00, "R9", d, 0);

        // R8: unserviced done, second byte lost
        run_xfer(8'h3C, 8'h3C, 1'b0, 8'h00);
        run_xfer(8'hC3, 8'hC3, 1'b0, 8'h00);
        bus_read(1'b0, d); chk(d == 8'h80, "R8", d, 8'h80);
        bus_read(1'b1, d); chk(d == 8'h3C, "R8", d, 8'h3C);
        bus_read(1'b0, d); chk(d == 8'h00, "R8", d, 0);
        run_xfer(8'h81, 8'hE4, 1'b1, 8'hE4);

        finish_run();
    end

endmodule